// File: doc/BRIEF.md
# Address-Pattern Partition Protector

This block guards a battery-backed memory against stray writes by splitting it into sixteen equal partitions and keeping a 16-bit protection map. The map can only be changed by a secret handshake that uses no data bus. Software issues twenty read cycles whose upper four address bits follow a fixed sequence. It then issues four more read cycles, and the upper nibbles of those four reads become the new map. Any write cycle aborts the handshake. A correct program never writes by accident in the middle of this sequence, so a program that has gone wrong is very unlikely to reprogram the map.

Once the map is loaded, the block raises a write-block flag whenever the current upper address nibble selects a protected partition. The surrounding logic uses this flag to hold the memory's write strobe inactive. Protection is armed by a disable-level input. That input is captured only when the supply-good flag changes state, so the setting survives a power loss. While the supply is bad, the block ignores all memory cycles.

The four address bits are named here w, x, y, z, with w as bit 0 and z as bit 3 of `addr`. A nibble value below is written as the hexadecimal value of {z,y,x,w}. All inputs are sampled on the rising edge of `clk`.

Top module: `part_protect`

## Requirements
- R1: After reset the matcher is at step 1 and the latched disable level is 0, so `wr_block` is 0. The protection map itself is not reset and is undefined until its first load.
- R2: A memory cycle starts at the first clock edge where `ce_n` is sampled low after being high, and the address is captured at that edge. The cycle ends at the first edge where `ce_n` is sampled high again. It is a read if `we_n` was sampled high at every edge in between, and a write otherwise.
- R3: The unlock sequence is twenty read cycles whose captured nibbles are, in order, F E 7 7 3 9 C E 7 3 9 4 2 4 A 6 9 1 0 5.
- R4: After a complete match, read k of the next four (k = 0..3) writes its nibble into map bits 4k+3..4k. Address bit w lands in the lowest of these four bits.
- R5: A write cycle at any point during matching or loading returns the matcher to step 1. Nibbles already loaded by that point are kept.
- R6: A read whose nibble differs from the expected step restarts matching. If that nibble equals the first sequence value F, matching continues at step 2; otherwise it continues at step 1.
- R7: After the fourth load read, the matcher returns to step 1. Further reads do not alter the map until a new full match.
- R8: `wr_block` equals the latched disable level ANDed with the map bit selected by the current `addr` value, read as {z,y,x,w}.
- R9: On every clock edge where `supply_ok` differs from its value at the previous edge, `dis` is captured into the disable latch. Changes of `dis` at any other time have no effect.
- R10: Memory cycles that end while `supply_ok` is low are ignored. Both the matcher progress and the map are held through the bad-supply interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 4 | Upper address nibble {z,y,x,w} |
| ce_n | input | 1 | Active-low chip enable from the host |
| we_n | input | 1 | Active-low write enable from the host |
| dis | input | 1 | Protection arm level, latched on supply transitions |
| supply_ok | input | 1 | High while the supply is within tolerance |
| wr_block | output | 1 | High when a write to the current partition must be suppressed |

## Verification
A matcher stuck at the wrong step, or one that advances on writes, shows up only when the four load reads arrive. If the map at that point holds the old value where a new one was expected, or the reverse, the error becomes visible within one probe of the sixteen partitions. A map bit in the wrong position, or a disable latch that follows `dis` at the wrong time, shows at once as a wrong `wr_block` on the affected partitions. The bench therefore compares `wr_block` against its own model on every settled clock. After each scenario, it also sweeps all sixteen address values.

// File: rtl/part_protect_pkg.sv
package part_protect_pkg;
    localparam int NIB_W   = 4;
    localparam int PARTS   = 1 << NIB_W;
    localparam int SEQ_LEN = 20;
    localparam int LOAD_N  = PARTS / NIB_W;
    localparam int TOTAL   = SEQ_LEN + LOAD_N;
    localparam int STEP_W  = $clog2(TOTAL + 1);
    localparam int IDX_W   = $clog2(LOAD_N);

    // unlock nibble for step idx, encoded {z,y,x,w}
    function automatic logic [NIB_W-1:0] seq_value(input int idx);
        logic [NIB_W-1:0] v;
        case (idx)
            0:  v = 4'hF;
            1:  v = 4'hE;
            2:  v = 4'h7;
            3:  v = 4'h7;
            4:  v = 4'h3;
            5:  v = 4'h9;
            6:  v = 4'hC;
            7:  v = 4'hE;
            8:  v = 4'h7;
            9:  v = 4'h3;
            10: v = 4'h9;
            11: v = 4'h4;
            12: v = 4'h2;
            13: v = 4'h4;
            14: v = 4'hA;
            15: v = 4'h6;
            16: v = 4'h9;
            17: v = 4'h1;
            18: v = 4'h0;
            default: v = 4'h5;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/part_cycle_mon.sv
module part_cycle_mon
    import part_protect_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             we_n,
    input  logic [NIB_W-1:0] addr,
    output logic             rd_done,
    output logic             wr_done,
    output logic [NIB_W-1:0] cyc_addr
);
    typedef struct packed {
        logic             ce_prev_n;
        logic             active;
        logic             wr_seen;
        logic             rd_done;
        logic             wr_done;
        logic [NIB_W-1:0] addr;
    } mon_t;

    mon_t mon_d, mon_q;

    always_comb begin
        mon_d           = mon_q;
        mon_d.rd_done   = 1'b0;
        mon_d.wr_done   = 1'b0;
        mon_d.ce_prev_n = ce_n;
        if (!ce_n && mon_q.ce_prev_n) begin
            mon_d.active  = 1'b1;
            mon_d.addr    = addr;
            mon_d.wr_seen = !we_n;
        end else if (!ce_n && mon_q.active) begin
            mon_d.wr_seen = mon_q.wr_seen | !we_n;
        end else if (ce_n && mon_q.active) begin
            mon_d.active  = 1'b0;
            mon_d.wr_done = mon_q.wr_seen;
            mon_d.rd_done = !mon_q.wr_seen;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q <= '{ce_prev_n: 1'b1, active: 1'b0, wr_seen: 1'b0,
                       rd_done: 1'b0, wr_done: 1'b0, addr: '0};
        end else begin
            mon_q <= mon_d;
        end
    end

    assign rd_done  = mon_q.rd_done;
    assign wr_done  = mon_q.wr_done;
    assign cyc_addr = mon_q.addr;

    // R2: a cycle only completes after chip enable was seen high
    p_done_on_ce_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done || wr_done) |-> $past(ce_n));
    // R2: a completed cycle is never both read and write
    p_one_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> !wr_done);
endmodule

// File: rtl/part_unlock_seq.sv
module part_unlock_seq
    import part_protect_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic             rd_done,
    input  logic             wr_done,
    input  logic [NIB_W-1:0] cyc_addr,
    output logic             load_en,
    output logic [IDX_W-1:0] load_idx
);
    localparam logic [STEP_W-1:0] SEQ_END   = STEP_W'(SEQ_LEN);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(TOTAL - 1);

    typedef struct packed {
        logic [STEP_W-1:0] step;
    } seq_t;

    seq_t seq_d, seq_q;
    logic adv_rd, adv_wr;

    assign adv_rd = rd_done && supply_ok;
    assign adv_wr = wr_done && supply_ok;

    always_comb begin
        seq_d    = seq_q;
        load_en  = 1'b0;
        load_idx = IDX_W'(seq_q.step - SEQ_END);
        if (adv_wr) begin
            seq_d.step = '0;
        end else if (adv_rd) begin
            if (seq_q.step < SEQ_END) begin
                if (cyc_addr == seq_value(int'(seq_q.step)))
                    seq_d.step = seq_q.step + 1'b1;
                else if (cyc_addr == seq_value(0))
                    seq_d.step = STEP_W'(1);
                else
                    seq_d.step = '0;
            end else begin
                load_en    = 1'b1;
                seq_d.step = (seq_q.step == LAST_STEP) ? '0 : seq_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{step: '0};
        else        seq_q <= seq_d;
    end

    // R10: no progress without a cycle completing under good supply
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(supply_ok && (rd_done || wr_done)) |=> $stable(seq_q.step));
    // R5: a write under good supply always returns to the first step
    p_write_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && wr_done) |=> (seq_q.step == '0));
    // R7: the step never runs past the last load read
    p_step_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.step <= LAST_STEP);
endmodule

// File: rtl/part_prot_map.sv
module part_prot_map
    import part_protect_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic             dis,
    input  logic             load_en,
    input  logic [IDX_W-1:0] load_idx,
    input  logic [NIB_W-1:0] load_nib,
    input  logic [NIB_W-1:0] addr,
    output logic             wr_block
);
    typedef struct packed {
        logic sup_prev;
        logic dis_lat;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [PARTS-1:0] map_d, map_q;

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.sup_prev = supply_ok;
        if (supply_ok != ctl_q.sup_prev) ctl_d.dis_lat = dis;
    end

    always_comb begin
        map_d = map_q;
        if (load_en) map_d[int'(load_idx)*NIB_W +: NIB_W] = load_nib;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{sup_prev: 1'b0, dis_lat: 1'b0};
        else        ctl_q <= ctl_d;
    end

    // protection map deliberately has no reset: it is retained storage
    always_ff @(posedge clk) begin
        map_q <= map_d;
    end

    assign wr_block = ctl_q.dis_lat & map_q[addr];

    // R9: the latch holds while the supply flag is steady
    p_dis_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok == ctl_q.sup_prev) |=> $stable(ctl_q.dis_lat));
    // R10: the map changes only on a load strobe
    p_map_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(map_q));
    // R8: blocking requires an armed latch
    p_block_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_block |-> ctl_q.dis_lat);
endmodule

// File: rtl/part_protect.sv
module part_protect
    import part_protect_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] addr,
    input  logic             ce_n,
    input  logic             we_n,
    input  logic             dis,
    input  logic             supply_ok,
    output logic             wr_block
);
    logic             rd_done, wr_done, load_en;
    logic [NIB_W-1:0] cyc_addr;
    logic [IDX_W-1:0] load_idx;

    part_cycle_mon u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .addr     (addr),
        .rd_done  (rd_done),
        .wr_done  (wr_done),
        .cyc_addr (cyc_addr)
    );

    part_unlock_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .supply_ok(supply_ok),
        .rd_done  (rd_done),
        .wr_done  (wr_done),
        .cyc_addr (cyc_addr),
        .load_en  (load_en),
        .load_idx (load_idx)
    );

    part_prot_map u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .supply_ok(supply_ok),
        .dis      (dis),
        .load_en  (load_en),
        .load_idx (load_idx),
        .load_nib (cyc_addr),
        .addr     (addr),
        .wr_block (wr_block)
    );

    // R10: a load never happens under bad supply
    p_no_load_bad_supply_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> supply_ok);
endmodule

// File: tb/part_protect_bench.sv
module part_protect_bench;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = 4'h0;
    logic       ce_n = 1'b1;
    logic       we_n = 1'b1;
    logic       dis = 1'b0;
    logic       supply_ok = 1'b0;
    logic       wr_block;

    int n_chk = 0;
    int n_bad = 0;

    // behavioural reference state
    logic [3:0]  pat [20];
    logic [15:0] m_map = 16'h0;
    bit          m_known = 0;
    bit          m_dis = 0;
    int          m_step = 0;
    bit          cmp_en = 0;

    always #(CLK_P/2) clk = ~clk;

    part_protect u_part_protect (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n),
        .dis(dis), .supply_ok(supply_ok), .wr_block(wr_block)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_block(input logic [3:0] a);
        return m_dis && m_map[a];
    endfunction

    // per-clock comparison, R8
    always @(posedge clk) begin
        #(CLK_P/4);
        if (cmp_en && m_known && rst_n)
            check(wr_block === exp_block(addr), "R8 per-clock", int'(wr_block), int'(exp_block(addr)));
    end

    function automatic void model_cycle(input logic [3:0] a, input bit is_wr);
        if (!supply_ok) return;
        if (is_wr) begin
            m_step = 0;
        end else if (m_step < 20) begin
            if (a == pat[m_step]) m_step++;
            else if (a == pat[0]) m_step = 1;
            else m_step = 0;
        end else begin
            m_map[(m_step-20)*4 +: 4] = a;
            if (m_step == 20) m_known = 1;
            m_step = (m_step == 23) ? 0 : m_step + 1;
        end
    endfunction

    task automatic mem_cycle(input logic [3:0] a, input bit is_wr);
        cmp_en = 0;
        @(negedge clk); addr = a; ce_n = 1'b0;
        @(negedge clk); if (is_wr) we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
        repeat (3) @(negedge clk);
        model_cycle(a, is_wr);
        cmp_en = 1;
    endtask

    task automatic send_steps(input int first, input int last);
        for (int i = first; i <= last; i++) mem_cycle(pat[i], 1'b0);
    endtask

    task automatic send_load(input logic [15:0] v);
        for (int k = 0; k < 4; k++) mem_cycle(v[k*4 +: 4], 1'b0);
    endtask

    task automatic set_supply(input bit v);
        @(negedge clk);
        if (supply_ok != v) m_dis = dis;
        supply_ok = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic sweep(input string tag);
        for (int p = 0; p < 16; p++) begin
            @(negedge clk); addr = 4'(p);
            @(posedge clk); #(CLK_P/4);
            check(wr_block === exp_block(4'(p)), tag, int'(wr_block), int'(exp_block(4'(p))));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        pat = '{4'hF,4'hE,4'h7,4'h7,4'h3,4'h9,4'hC,4'hE,4'h7,4'h3,
                4'h9,4'h4,4'h2,4'h4,4'hA,4'h6,4'h9,4'h1,4'h0,4'h5};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #(CLK_P/4);
        check(wr_block === 1'b0, "R1 reset block low", int'(wr_block), 0);

        // arm the latch with a supply rise, R9
        dis = 1'b1;
        set_supply(1'b1);

        // R3 R4: full unlock and load
        send_steps(0, 19);
        send_load(16'hA5C3);
        sweep("R4 map after first load");

        // R7: extra reads after loading do not touch the map
        mem_cycle(4'h0, 1'b0);
        mem_cycle(4'hF, 1'b0);
        send_load(16'h0000);
        sweep("R7 no reload without match");

        // R5: write mid sequence aborts
        mem_cycle(4'h1, 1'b0);
        send_steps(0, 9);
        mem_cycle(4'h3, 1'b1);
        send_steps(10, 19);
        send_load(16'hFFFF);
        sweep("R5 write aborts unlock");

        // R6: mismatch equal to first value resumes at step 2
        send_steps(0, 4);
        mem_cycle(4'hF, 1'b0);
        send_steps(1, 19);
        send_load(16'h1248);
        sweep("R6 restart at step two");

        // R6: other mismatch restarts from step 1
        send_steps(0, 6);
        mem_cycle(4'hB, 1'b0);
        send_steps(7, 19);
        send_load(16'h7777);
        sweep("R6 restart at step one");

        // R5: write during load keeps loaded nibbles, drops the rest
        send_steps(0, 19);
        mem_cycle(4'h9, 1'b0);
        mem_cycle(4'h6, 1'b0);
        mem_cycle(4'h2, 1'b1);
        mem_cycle(4'h0, 1'b0);
        mem_cycle(4'h0, 1'b0);
        sweep("R5 partial load kept");

        // R10: cycles under bad supply are ignored, progress held
        send_steps(0, 9);
        set_supply(1'b0);
        mem_cycle(4'h0, 1'b1);
        mem_cycle(4'h8, 1'b0);
        set_supply(1'b1);
        send_steps(10, 19);
        send_load(16'h5AF0);
        sweep("R10 progress held over bad supply");
        set_supply(1'b0);
        send_steps(0, 19);
        send_load(16'h0000);
        set_supply(1'b1);
        sweep("R10 map held over bad supply");

        // R9: dis ignored while supply steady, captured on transition
        dis = 1'b0;
        repeat (3) @(negedge clk);
        sweep("R9 dis change ignored");
        set_supply(1'b0);
        set_supply(1'b1);
        sweep("R9 disarmed after transition");
        dis = 1'b1;
        repeat (3) @(negedge clk);
        sweep("R9 rearm ignored without transition");
        set_supply(1'b0);
        sweep("R9 armed on falling supply");

        // R2: a long read still counts as one read
        set_supply(1'b1);
        cmp_en = 0;
        send_steps(0, 18);
        @(negedge clk); addr = pat[19]; ce_n = 1'b0;
        repeat (6) @(negedge clk);
        ce_n = 1'b1;
        repeat (3) @(negedge clk);
        model_cycle(pat[19], 1'b0);
        send_load(16'hC00C);
        sweep("R2 long read counted once");

        cmp_en = 0;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule